// File: doc/BRIEF.md
# Banked Byte Data Memory with Bit Operations

This unit is the byte-wide data store of a small controller core. The 8-bit address space splits at 40H. Addresses 40H and above hold general purpose RAM. That RAM has two banks, and the bank select input picks one. Addresses below 40H hold special function registers, and these are the same whatever bank is selected. The register contents live outside this unit and are reached through a simple read/write port. A parameter mask says which low addresses are implemented. A second mask marks some of those as read-only.

Each request carries one of four operations: read a byte, write a byte, set one bit, or clear one bit. A bit operation reads the addressed byte, changes the selected bit and writes the byte back, all in the request cycle. The address can come straight from the request or, for indirect access, from one of two memory pointer inputs. In both cases the bank select still chooses the RAM bank. Read data comes out of a register one cycle after the read request.

Top module: `banked_dmem`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `rdata` becomes 00H and every general purpose RAM byte in both banks becomes 00H.
- R2: Addresses 40H to FFH reach general purpose RAM. Bank 0 and bank 1 each hold 192 independent bytes, chosen by `bank_sel` (0 = bank 0, 1 = bank 1).
- R3: Below 40H, `sfr_addr` equals the low six bits of the effective address for any `bank_sel` value, so both banks see the same registers.
- R4: A read of an address below 40H whose bit is clear in `SFR_IMPL` returns 00H.
- R5: A write, bit set or bit clear to an address below 40H never raises `sfr_we` when the address is unimplemented or its bit is set in `SFR_RO`. A later read returns the unchanged value.
- R6: `op` = 2 sets bit `bit_idx` (0 = least significant) and `op` = 3 clears it. The other seven bits keep their values, and the change is visible to a read on the next request.
- R7: `op` = 0 is a byte read and `op` = 1 is a byte write of `wdata`. Either one acts only when `req` is high.
- R8: When `ind_en` is 1, the effective address is `mp0` if `ptr_sel` is 0 and `mp1` if `ptr_sel` is 1, and `addr` is ignored.
- R9: In indirect mode, `bank_sel` still selects the general purpose RAM bank.
- R10: `rdata` shows the read byte at the first rising edge after the read request. It keeps its value across every cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid this cycle |
| op | input | 2 | 0 read, 1 write, 2 bit set, 3 bit clear |
| addr | input | 8 | Direct address |
| bank_sel | input | 1 | General purpose RAM bank |
| bit_idx | input | 3 | Bit position for set/clear |
| wdata | input | 8 | Byte to write |
| ind_en | input | 1 | Use a pointer instead of `addr` |
| ptr_sel | input | 1 | 0 selects `mp0`, 1 selects `mp1` |
| mp0 | input | 8 | Memory pointer 0 |
| mp1 | input | 8 | Memory pointer 1 |
| rdata | output | 8 | Registered read data |
| sfr_addr | output | 6 | Register index for the external register file |
| sfr_rdata | input | 8 | Combinational contents of register `sfr_addr` |
| sfr_we | output | 1 | Register write strobe |
| sfr_wdata | output | 8 | Register write byte |

## Verification
The assertions assume that every request field is a known binary value while `req` is high. They also assume the external register file returns `sfr_rdata` combinationally for the `sfr_addr` of the same cycle. The bench meets this by drawing each field from a seeded `$urandom` masked to its width. It changes inputs only at the falling edge, and it models the register file as a plain array indexed by `sfr_addr`. Directed cases cover implemented, unimplemented and read-only registers, both pointers, and both ends of the bit index.

// File: rtl/dmem_pkg.sv
// Shared types for the banked data memory.
// Assumes: the operation code is two bits wide and fully decoded.
package dmem_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_BSET  = 2'd2,
        OP_BCLR  = 2'd3
    } dmem_op_e;

endpackage

// File: rtl/dmem_addr_dec.sv
// Effective-address selection and region decode.
// Picks the direct address or one of two pointers, then reports whether the
// result falls in the shared register region (with implemented/read-only
// flags) or in general purpose RAM (with the RAM index).
// Assumes: SFR_SPAN is a power of two and smaller than the address space.
module dmem_addr_dec #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned SFR_SPAN = 64,
    parameter logic [SFR_SPAN-1:0] SFR_IMPL = '1,
    parameter logic [SFR_SPAN-1:0] SFR_RO   = '0,
    localparam int unsigned SFR_AW  = $clog2(SFR_SPAN),
    localparam int unsigned GPR_N   = (1 << ADDR_W) - SFR_SPAN,
    localparam int unsigned GIDX_W  = $clog2(GPR_N)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ind_en,
    input  logic              ptr_sel,
    input  logic [ADDR_W-1:0] mp0,
    input  logic [ADDR_W-1:0] mp1,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              in_sfr,
    output logic              sfr_impl,
    output logic              sfr_ro,
    output logic [SFR_AW-1:0] sfr_idx,
    output logic [GIDX_W-1:0] gpr_idx
);

    logic [ADDR_W-1:0] ptr_val;
    logic [ADDR_W-1:0] gpr_off;

    // Choose the pointer register named by ptr_sel.
    always_comb begin
        ptr_val = ptr_sel ? mp1 : mp0;
    end

    // Direct address unless indirect access is requested.
    always_comb begin
        eff_addr = ind_en ? ptr_val : addr;
    end

    // Region decode and per-register flags.
    always_comb begin
        in_sfr   = (eff_addr < ADDR_W'(SFR_SPAN));
        sfr_idx  = eff_addr[SFR_AW-1:0];
        sfr_impl = in_sfr && SFR_IMPL[sfr_idx];
        sfr_ro   = in_sfr && SFR_RO[sfr_idx];
        gpr_off  = eff_addr - ADDR_W'(SFR_SPAN);
        gpr_idx  = GIDX_W'(gpr_off);
    end

endmodule

// File: rtl/dmem_bit_alu.sv
// Byte modifier for the write path.
// Produces the byte to store: the write data for a byte write, or the old
// byte with one bit forced high or low for the bit operations.
// Assumes: the caller suppresses the store for reads.
module dmem_bit_alu
    import dmem_pkg::*;
#(
    parameter int unsigned DW = 8,
    localparam int unsigned BIT_W = $clog2(DW)
) (
    input  dmem_op_e          op,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [DW-1:0]     old_byte,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     new_byte
);

    logic [DW-1:0] bit_mask;

    // One-hot mask for the addressed bit.
    always_comb begin
        bit_mask = '0;
        bit_mask[bit_idx] = 1'b1;
    end

    // Merge according to the operation.
    always_comb begin
        unique case (op)
            OP_WRITE: new_byte = wdata;
            OP_BSET:  new_byte = old_byte | bit_mask;
            OP_BCLR:  new_byte = old_byte & ~bit_mask;
            default:  new_byte = old_byte;
        endcase
    end

endmodule

// File: rtl/dmem_gpr_array.sv
// General purpose RAM: NBANK banks of DEPTH bytes in flip-flops.
// The read is combinational, so a read-modify-write finishes in one cycle.
// Assumes: idx < DEPTH whenever we is high or the read data is used.
module dmem_gpr_array #(
    parameter int unsigned NBANK = 2,
    parameter int unsigned DEPTH = 192,
    parameter int unsigned DW    = 8,
    localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] bank,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DW-1:0]     wbyte,
    output logic [DW-1:0]     rbyte
);

    logic [DW-1:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];
        logic          bank_hit;

        // Decode whether this bank is the one being accessed.
        always_comb begin
            bank_hit = (bank == BANK_W'(b));
        end

        // Clear on reset, otherwise store on a write hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] <= '0;
                end
            end else if (we && bank_hit) begin
                mem[idx] <= wbyte;
            end
        end

        // Combinational read of this bank.
        always_comb begin
            bank_rd[b] = mem[idx];
        end
    end

    // Return the byte from the selected bank.
    always_comb begin
        rbyte = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bank == BANK_W'(b)) begin
                rbyte = bank_rd[b];
            end
        end
    end

endmodule

// File: rtl/banked_dmem.sv
// Banked data memory top.
// Decodes the effective address, reads the old byte from RAM or the external
// register port, applies the requested change and stores the result. Read
// data is registered.
// Assumes: sfr_rdata reflects sfr_addr within the same cycle.
module banked_dmem
    import dmem_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DW       = 8,
    parameter int unsigned NBANK    = 2,
    parameter int unsigned SFR_SPAN = 64,
    parameter logic [63:0] SFR_IMPL = 64'h00FF_0000_3FFF_FF7F,
    parameter logic [63:0] SFR_RO   = 64'h0000_0000_0000_0030,
    localparam int unsigned SFR_AW  = $clog2(SFR_SPAN),
    localparam int unsigned GPR_N   = (1 << ADDR_W) - SFR_SPAN,
    localparam int unsigned GIDX_W  = $clog2(GPR_N),
    localparam int unsigned BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int unsigned BIT_W   = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [DW-1:0]     wdata,
    input  logic              ind_en,
    input  logic              ptr_sel,
    input  logic [ADDR_W-1:0] mp0,
    input  logic [ADDR_W-1:0] mp1,
    output logic [DW-1:0]     rdata,
    output logic [SFR_AW-1:0] sfr_addr,
    input  logic [DW-1:0]     sfr_rdata,
    output logic              sfr_we,
    output logic [DW-1:0]     sfr_wdata
);

    dmem_op_e          op_e;
    logic [ADDR_W-1:0] eff_addr;
    logic              in_sfr;
    logic              sfr_impl;
    logic              sfr_ro;
    logic [SFR_AW-1:0] sfr_idx;
    logic [GIDX_W-1:0] gpr_idx;
    logic [DW-1:0]     gpr_rbyte;
    logic [DW-1:0]     old_byte;
    logic [DW-1:0]     new_byte;
    logic              is_store;
    logic              gpr_we;

    // Cast the raw code to the operation type.
    always_comb begin
        op_e = dmem_op_e'(op);
    end

    dmem_addr_dec #(
        .ADDR_W   (ADDR_W),
        .SFR_SPAN (SFR_SPAN),
        .SFR_IMPL (SFR_IMPL[SFR_SPAN-1:0]),
        .SFR_RO   (SFR_RO[SFR_SPAN-1:0])
    ) u_dec (
        .addr     (addr),
        .ind_en   (ind_en),
        .ptr_sel  (ptr_sel),
        .mp0      (mp0),
        .mp1      (mp1),
        .eff_addr (eff_addr),
        .in_sfr   (in_sfr),
        .sfr_impl (sfr_impl),
        .sfr_ro   (sfr_ro),
        .sfr_idx  (sfr_idx),
        .gpr_idx  (gpr_idx)
    );

    dmem_gpr_array #(
        .NBANK (NBANK),
        .DEPTH (GPR_N),
        .DW    (DW)
    ) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpr_we),
        .bank  (bank_sel),
        .idx   (gpr_idx),
        .wbyte (new_byte),
        .rbyte (gpr_rbyte)
    );

    // Old byte: RAM, external register, or zero for a hole.
    always_comb begin
        if (!in_sfr) begin
            old_byte = gpr_rbyte;
        end else if (sfr_impl) begin
            old_byte = sfr_rdata;
        end else begin
            old_byte = '0;
        end
    end

    dmem_bit_alu #(
        .DW (DW)
    ) u_alu (
        .op       (op_e),
        .bit_idx  (bit_idx),
        .old_byte (old_byte),
        .wdata    (wdata),
        .new_byte (new_byte)
    );

    // Store enables for each region.
    always_comb begin
        is_store  = req && (op_e != OP_READ);
        gpr_we    = is_store && !in_sfr;
        sfr_we    = is_store && sfr_impl && !sfr_ro;
        sfr_addr  = sfr_idx;
        sfr_wdata = new_byte;
    end

    // Capture read data, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (req && (op_e == OP_READ)) begin
            rdata <= old_byte;
        end
    end

endmodule

// File: rtl/banked_dmem_chk.sv
// Property checker for banked_dmem, bound to every instance.
// Assumes: request fields are known while req is high.
module banked_dmem_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DW       = 8,
    parameter int unsigned BANK_W   = 1,
    parameter int unsigned SFR_AW   = 6,
    parameter int unsigned BIT_W    = 3,
    parameter logic [63:0] SFR_IMPL = '1,
    parameter logic [63:0] SFR_RO   = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [1:0]        op,
    input logic [ADDR_W-1:0] addr,
    input logic [BANK_W-1:0] bank_sel,
    input logic [BIT_W-1:0]  bit_idx,
    input logic [DW-1:0]     wdata,
    input logic              ind_en,
    input logic              ptr_sel,
    input logic [ADDR_W-1:0] mp0,
    input logic [ADDR_W-1:0] mp1,
    input logic [DW-1:0]     rdata,
    input logic [SFR_AW-1:0] sfr_addr,
    input logic [DW-1:0]     sfr_rdata,
    input logic              sfr_we,
    input logic [DW-1:0]     sfr_wdata
);

    logic [ADDR_W-1:0] ea_c;
    logic              low_c;

    // Independent view of the effective address.
    always_comb begin
        ea_c  = ind_en ? (ptr_sel ? mp1 : mp0) : addr;
        low_c = (ea_c < ADDR_W'(1 << SFR_AW));
    end

    AST_RESET_RDATA: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0)); // R1

    AST_SFR_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (req && low_c) |-> (sfr_addr == ea_c[SFR_AW-1:0])); // R3

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req && op == 2'd0 && low_c && !SFR_IMPL[ea_c[SFR_AW-1:0]])
        |=> (rdata == '0)); // R4

    AST_NO_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_we |-> (req && op != 2'd0 && low_c
                    && SFR_IMPL[ea_c[SFR_AW-1:0]]
                    && !SFR_RO[ea_c[SFR_AW-1:0]])); // R5

    AST_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && op == 2'd2) |-> (sfr_wdata[bit_idx] == 1'b1)); // R6

    AST_BIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && op == 2'd3) |-> (sfr_wdata[bit_idx] == 1'b0)); // R6

    AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && op == 2'd1) |-> (sfr_wdata == wdata)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && op == 2'd0) |=> $stable(rdata)); // R10

endmodule

bind banked_dmem banked_dmem_chk #(
    .ADDR_W   (ADDR_W),
    .DW       (DW),
    .BANK_W   (BANK_W),
    .SFR_AW   (SFR_AW),
    .BIT_W    (BIT_W),
    .SFR_IMPL (SFR_IMPL),
    .SFR_RO   (SFR_RO)
) u_chk (.*);

// File: tb/banked_dmem_tb.sv
module banked_dmem_tb;

    localparam logic [63:0] IMPL = 64'h00FF_0000_3FFF_FF7F;
    localparam logic [63:0] RO   = 64'h0000_0000_0000_0030;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req;
    logic [1:0] op;
    logic [7:0] addr;
    logic       bank_sel;
    logic [2:0] bit_idx;
    logic [7:0] wdata;
    logic       ind_en;
    logic       ptr_sel;
    logic [7:0] mp0;
    logic [7:0] mp1;
    logic [7:0] rdata;
    logic [5:0] sfr_addr;
    logic [7:0] sfr_rdata;
    logic       sfr_we;
    logic [7:0] sfr_wdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] sfr_file [64];
    logic [7:0] exp_sfr  [64];
    logic [7:0] exp_gpr  [2][192];

    always #10 clk = ~clk;

    banked_dmem u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr),
        .bank_sel(bank_sel), .bit_idx(bit_idx), .wdata(wdata),
        .ind_en(ind_en), .ptr_sel(ptr_sel), .mp0(mp0), .mp1(mp1),
        .rdata(rdata), .sfr_addr(sfr_addr), .sfr_rdata(sfr_rdata),
        .sfr_we(sfr_we), .sfr_wdata(sfr_wdata)
    );

    // External register file seen by the block.
    assign sfr_rdata = sfr_file[sfr_addr];
    always @(posedge clk) begin
        if (sfr_we) sfr_file[sfr_addr] <= sfr_wdata;
    end

    function automatic logic [7:0] f_ea(logic [7:0] a, logic ind, logic ps,
                                        logic [7:0] p0, logic [7:0] p1);
        return ind ? (ps ? p1 : p0) : a;
    endfunction

    function automatic logic [7:0] f_old(logic [7:0] ea, logic bk);
        if (ea >= 8'h40) return exp_gpr[bk][ea - 8'h40];
        if (!IMPL[ea[5:0]]) return 8'h00;
        return exp_sfr[ea[5:0]];
    endfunction

    function automatic logic [7:0] f_new(logic [1:0] o, logic [2:0] b,
                                         logic [7:0] old, logic [7:0] wd);
        case (o)
            2'd1:    return wd;
            2'd2:    return old | (8'h01 << b);
            2'd3:    return old & ~(8'h01 << b);
            default: return old;
        endcase
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string r);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", r, act, exp);
        end
    endtask

    // One request; compares rdata after the edge and updates the model.
    task automatic do_op(logic [1:0] o, logic [7:0] a, logic bk,
                         logic [2:0] b, logic [7:0] wd, logic ind,
                         logic ps, logic [7:0] p0, logic [7:0] p1,
                         string r);
        logic [7:0] ea;
        logic [7:0] old;
        logic [7:0] prev;
        @(negedge clk);
        req = 1'b1; op = o; addr = a; bank_sel = bk; bit_idx = b;
        wdata = wd; ind_en = ind; ptr_sel = ps; mp0 = p0; mp1 = p1;
        ea   = f_ea(a, ind, ps, p0, p1);
        old  = f_old(ea, bk);
        prev = rdata;
        @(negedge clk);
        req = 1'b0;
        if (o == 2'd0) begin
            check(rdata, old, r);
        end else begin
            check(rdata, prev, "R10 hold");
            if (ea >= 8'h40) exp_gpr[bk][ea - 8'h40] = f_new(o, b, old, wd);
            else if (IMPL[ea[5:0]] && !RO[ea[5:0]])
                exp_sfr[ea[5:0]] = f_new(o, b, old, wd);
        end
    endtask

    task automatic rd(logic [7:0] a, logic bk, string r);
        do_op(2'd0, a, bk, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, r);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 64; i++) begin
            sfr_file[i] = 8'(i * 7 + 3);
            exp_sfr[i]  = 8'(i * 7 + 3);
        end
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 192; i++) exp_gpr[k][i] = 8'h00;
        rst_n = 1'b0; req = 1'b0; op = 2'd0; addr = 8'h00; bank_sel = 1'b0;
        bit_idx = 3'd0; wdata = 8'h00; ind_en = 1'b0; ptr_sel = 1'b0;
        mp0 = 8'h00; mp1 = 8'h00;
        repeat (3) @(negedge clk);
        check(rdata, 8'h00, "R1 rdata reset");
        rst_n = 1'b1;
        rd(8'h40, 1'b0, "R1 ram cleared");
        rd(8'hFF, 1'b1, "R1 ram cleared");

        // Bank independence at the top and bottom of the RAM range.
        do_op(2'd1, 8'h40, 1'b0, 3'd0, 8'hA5, 1'b0, 1'b0, 8'h00, 8'h00, "R7");
        do_op(2'd1, 8'h40, 1'b1, 3'd0, 8'h5A, 1'b0, 1'b0, 8'h00, 8'h00, "R7");
        rd(8'h40, 1'b0, "R2 bank0");
        rd(8'h40, 1'b1, "R2 bank1");
        do_op(2'd1, 8'hFF, 1'b1, 3'd0, 8'h3C, 1'b0, 1'b0, 8'h00, 8'h00, "R7");
        rd(8'hFF, 1'b1, "R2 top byte");
        rd(8'hFF, 1'b0, "R2 other bank");

        // Shared registers from both banks.
        do_op(2'd1, 8'h10, 1'b0, 3'd0, 8'hC3, 1'b0, 1'b0, 8'h00, 8'h00, "R7");
        rd(8'h10, 1'b1, "R3 shared");
        rd(8'h10, 1'b0, "R3 shared");

        // Holes and read-only registers.
        rd(8'h07, 1'b0, "R4 hole");
        rd(8'h3F, 1'b1, "R4 hole");
        do_op(2'd1, 8'h07, 1'b0, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h00, 8'h00, "R5");
        rd(8'h07, 1'b0, "R5 hole write ignored");
        check(sfr_file[7], 8'(7 * 7 + 3), "R5 hole no strobe");
        do_op(2'd1, 8'h04, 1'b0, 3'd0, 8'hEE, 1'b0, 1'b0, 8'h00, 8'h00, "R5");
        do_op(2'd2, 8'h05, 1'b1, 3'd7, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, "R5");
        rd(8'h04, 1'b0, "R5 read-only write");
        rd(8'h05, 1'b0, "R5 read-only bit set");

        // Bit index ends.
        do_op(2'd2, 8'h80, 1'b0, 3'd7, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, "R6");
        do_op(2'd2, 8'h80, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, "R6");
        rd(8'h80, 1'b0, "R6 set 7 and 0");
        do_op(2'd3, 8'h10, 1'b0, 3'd7, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, "R6");
        rd(8'h10, 1'b0, "R6 clear on register");

        // Indirect through each pointer, bank still applies.
        do_op(2'd1, 8'h00, 1'b1, 3'd0, 8'h77, 1'b1, 1'b1, 8'h50, 8'h90, "R8");
        rd(8'h90, 1'b1, "R8 mp1 target");
        rd(8'h90, 1'b0, "R9 bank in indirect");
        do_op(2'd0, 8'h90, 1'b1, 3'd0, 8'h00, 1'b1, 1'b0, 8'h90, 8'h41, "R8 mp0");
        do_op(2'd0, 8'h90, 1'b1, 3'd0, 8'h00, 1'b1, 1'b1, 8'h41, 8'h90, "R9 mp1");

        // Random mix.
        for (int i = 0; i < 1500; i++) begin
            do_op(2'($urandom), 8'($urandom), 1'($urandom), 3'($urandom),
                  8'($urandom), 1'($urandom), 1'($urandom),
                  8'($urandom), 8'($urandom), "R2 R6 R8 random");
        end
        for (int i = 0; i < 64; i++) rd(8'(i), 1'($urandom), "R3 R4 sweep");
        finish_run();
    end

endmodule